// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

This block moves a run of bytes from one place on a shared byte-wide system bus to another, so that the processor only sets the job up and handles its completion. Software loads a source pointer, a destination pointer and a byte count through a small register port, then writes a start command. The engine requests the bus, waits for a grant, and copies each byte by reading it at the source address and writing it at the destination address on the next cycle.

There are two ways to share the bus. In burst mode the engine keeps the bus for the whole block. In cycle-steal mode it holds the bus for exactly one byte per tenure. It then drops its request for at least one cycle so the arbiter can serve the processor, and asks again. When the last byte has been written the engine raises a level interrupt. The interrupt stays up until software clears it.

Top module: `dmac_core`

## Requirements
- R1: After a synchronous active-low reset, the pointers and count read as zero, busy and the interrupt are low, the bus request is low, and mem_addr, mem_wdata, mem_re and mem_we are all zero.
- R2: The register port selects with cfg_sel: 0 = source pointer, 1 = destination pointer, 2 = byte count, 3 = control. Each value reads back on cfg_rdata, zero-extended. A control write uses bit 0 = start, bit 1 = mode (1 = cycle steal, 0 = burst) and bit 2 = interrupt clear. A control read returns bit 0 = busy, bit 1 = mode and bit 2 = interrupt pending.
- R3: After a start, bus_req goes high. While bus_gnt is low the engine performs no bus access: mem_addr, mem_wdata, mem_re and mem_we stay zero.
- R4: Each byte is moved as a read of the source address followed, on the next cycle, by a write of the returned byte to the destination address. After each write both pointers advance by one and the count drops by one, so at the end the count reads zero and the source pointer reads its start value plus the length.
- R5: In burst mode bus_req stays high without a break from the start until the last byte is written, which gives exactly one bus tenure per block.
- R6: In cycle-steal mode every tenure carries exactly one byte. bus_req is low for at least one cycle between tenures, so a block of N bytes takes N tenures.
- R7: The interrupt rises only after the last byte of the block is written, never while busy. It stays high until a control write with bit 2 set clears it.
- R8: Register writes made while busy have no effect on the pointers, the count or the mode.
- R9: A start with a count of zero raises the interrupt on the next cycle, never asserts bus_req, and leaves busy low.
- R10: The pointers wrap modulo 2^ADDR_W, so a block that crosses the top of the address space continues at address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Read data of the selected register |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | ADDR_W | Bus address, zero when not owning the bus |
| mem_re | output | 1 | Read strobe; data returns on the next cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| irq | output | 1 | Block-complete interrupt, level |

## Verification
The bench builds the engine with ADDR_W, CNT_W and REG_W all set to 8, so the whole address space is a 256-byte memory model in the bench. At that size a block that starts at 0xFE crosses the top of the space after two bytes, which brings the pointer wrap of R10 within reach, and a full register write covers every bit of each field. A bench arbiter that can hold back the grant exposes the waiting behaviour of R3 and provides a busy window long enough to try the writes that R8 says are ignored.

// File: rtl/dmac_pkg.sv
// Package: shared state encoding and register-map constants for the copy engine.
// Assumes: nothing beyond IEEE 1800-2017.
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_GAP  = 3'd4
    } dma_state_e;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam int CTL_GO    = 0;
    localparam int CTL_STEAL = 1;
    localparam int CTL_ICLR  = 2;

endpackage

// File: rtl/dmac_regfile.sv
// Module: dmac_regfile
// Holds the source pointer, destination pointer, byte count, mode and the
// pending interrupt. Software writes are taken only while the engine is idle.
// The engine advances the pointers and the count with a one-cycle step pulse.
// Assumes: REG_W >= ADDR_W, REG_W >= CNT_W, REG_W >= 3.
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              busy_i,
    input  logic              step_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              steal_o,
    output logic              irq_o,
    output logic              cnt_zero_o,
    output logic              cnt_last_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              steal_q;
    logic              irq_q;
    logic              wr_ok;

    // Purpose: accept software writes only while idle.
    assign wr_ok   = cfg_wr && !busy_i;
    assign start_o = wr_ok && (cfg_sel == SEL_CTL) && cfg_wdata[CTL_GO];

    // Purpose: load pointers/count/mode, advance on step, track interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            steal_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (cfg_sel)
                    SEL_SRC: src_q <= cfg_wdata[ADDR_W-1:0];
                    SEL_DST: dst_q <= cfg_wdata[ADDR_W-1:0];
                    SEL_CNT: cnt_q <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        steal_q <= cfg_wdata[CTL_STEAL];
                        if (cfg_wdata[CTL_ICLR]) irq_q <= 1'b0;
                    end
                endcase
            end
            if (step_i) begin
                src_q <= src_q + 1'b1;
                dst_q <= dst_q + 1'b1;
                cnt_q <= cnt_q - 1'b1;
            end
            if (done_i) irq_q <= 1'b1;
        end
    end

    // Purpose: read multiplexer, zero-extended to the port width.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_SRC: cfg_rdata[ADDR_W-1:0] = src_q;
            SEL_DST: cfg_rdata[ADDR_W-1:0] = dst_q;
            SEL_CNT: cfg_rdata[CNT_W-1:0]  = cnt_q;
            default: begin
                cfg_rdata[CTL_GO]    = busy_i;
                cfg_rdata[CTL_STEAL] = steal_q;
                cfg_rdata[CTL_ICLR]  = irq_q;
            end
        endcase
    end

    assign src_o      = src_q;
    assign dst_o      = dst_q;
    assign steal_o    = steal_q;
    assign irq_o      = irq_q;
    assign cnt_zero_o = (cnt_q == '0);
    assign cnt_last_o = (cnt_q == CNT_ONE);

    // R8: while busy, only the engine's step moves the transfer state.
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !step_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(steal_q)));

    // R7: the interrupt rises only once the engine is idle with the count exhausted.
    assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (!busy_i && cnt_q == '0));

    // R4: each step advances the source pointer by exactly one.
    assert_step_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && busy_i) |=> (src_q == $past(src_q) + 1'b1));

endmodule

// File: rtl/dmac_engine.sv
// Module: dmac_engine
// Transfer sequencer: requests the bus, then runs read/write pairs. In burst
// mode it keeps the bus until the block ends. In cycle-steal mode it releases
// the bus for one cycle after each byte.
// Assumes: the arbiter keeps bus_gnt high for as long as bus_req stays high.
module dmac_engine
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cnt_zero_i,
    input  logic cnt_last_i,
    input  logic steal_i,
    input  logic gnt_i,
    output logic bus_req_o,
    output logic busy_o,
    output logic rd_o,
    output logic wr_o,
    output logic step_o,
    output logic done_o
);

    dma_state_e state_q;
    dma_state_e state_d;

    // Purpose: next-state and completion decode.
    always_comb begin
        state_d = state_q;
        done_o  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (cnt_zero_i) done_o  = 1'b1;
                    else            state_d = ST_REQ;
                end
            end
            ST_REQ:  if (gnt_i) state_d = ST_RD;
            ST_RD:   state_d = ST_WR;
            ST_WR: begin
                if (cnt_last_i) begin
                    state_d = ST_IDLE;
                    done_o  = 1'b1;
                end else if (steal_i) begin
                    state_d = ST_GAP;
                end else begin
                    state_d = ST_RD;
                end
            end
            ST_GAP:  state_d = ST_REQ;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign bus_req_o = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
    assign rd_o      = (state_q == ST_RD);
    assign wr_o      = (state_q == ST_WR);
    assign step_o    = wr_o;

    // R1: no request while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    // R3: no data phase starts without a grant.
    assert_wait_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !rd_o && !wr_o && !gnt_i) |=> !rd_o);

    // R5: in burst mode the request holds until the block completes.
    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !steal_i && !done_o) |=> bus_req_o);

    // R6: in cycle-steal mode each byte write is followed by a released request.
    assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && steal_i) |=> !bus_req_o);

    // R9: a zero-length start never requests the bus.
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cnt_zero_i) |=> (!bus_req_o && !busy_o));

endmodule

// File: rtl/dmac_busport.sv
// Module: dmac_busport
// Drives the memory-side bus: the source address with a read strobe in the
// read phase, the destination address with the returned byte in the write
// phase, and all zeros whenever the engine does not own the bus.
// Assumes: synchronous memory returning read data one cycle after mem_re.
module dmac_busport #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    logic own_rd;
    logic own_wr;

    // Purpose: a phase counts only while the grant is held.
    assign own_rd = gnt_i && rd_i;
    assign own_wr = gnt_i && wr_i;

    // Purpose: bus output multiplexer with zero default.
    always_comb begin
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        if (own_rd) begin
            mem_addr_o = src_i;
            mem_re_o   = 1'b1;
        end else if (own_wr) begin
            mem_addr_o  = dst_i;
            mem_wdata_o = rdata_i;
            mem_we_o    = 1'b1;
        end
    end

    // R4: every read is followed on the next cycle by the matching write.
    assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> mem_we_o);

    // R4: a write is never issued without the read that precedes it.
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_re_o));

endmodule

// File: rtl/dmac_core.sv
// Module: dmac_core (top)
// Single-channel block copy engine with burst and cycle-steal bus sharing.
// Assumes: REG_W >= ADDR_W, REG_W >= CNT_W, REG_W >= 3; byte-wide bus.
module dmac_core #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              irq
);

    localparam int DATA_W = 8;

    logic              start;
    logic              busy;
    logic              step;
    logic              done;
    logic              steal;
    logic              cnt_zero;
    logic              cnt_last;
    logic              rd_ph;
    logic              wr_ph;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;

    dmac_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .busy_i     (busy),
        .step_i     (step),
        .done_i     (done),
        .start_o    (start),
        .src_o      (src),
        .dst_o      (dst),
        .steal_o    (steal),
        .irq_o      (irq),
        .cnt_zero_o (cnt_zero),
        .cnt_last_o (cnt_last)
    );

    dmac_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cnt_zero_i (cnt_zero),
        .cnt_last_i (cnt_last),
        .steal_i    (steal),
        .gnt_i      (bus_gnt),
        .bus_req_o  (bus_req),
        .busy_o     (busy),
        .rd_o       (rd_ph),
        .wr_o       (wr_ph),
        .step_o     (step),
        .done_o     (done)
    );

    dmac_busport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt_i       (bus_gnt),
        .rd_i        (rd_ph),
        .wr_i        (wr_ph),
        .src_i       (src),
        .dst_i       (dst),
        .rdata_i     (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_re_o    (mem_re),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata)
    );

    // R7: the interrupt never coexists with a running transfer it did not precede.
    assert_no_irq_rise_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !irq) |=> !(busy && irq));

endmodule

// File: tb/dmac_core_bench.sv
// Scoreboard bench: the driver pushes the expected writes, and a negedge monitor pops and compares them.
module dmac_core_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 8;
    localparam int  CW = 8;
    localparam int  RW = 8;
    localparam int  WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic [7:0]    mem_rdata = 8'd0;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic          irq;

    logic          arb_hold = 1'b0;
    logic [7:0]    mem [256];

    int tests = 0;
    int fails = 0;
    int tenures = 0;
    int low_run = 0;
    int gap_bad = 0;
    int quiet_bad = 0;
    int irq_bad = 0;
    int reads_seen = 0;
    int cycles = 0;
    logic prev_req = 1'b0;
    logic [15:0] exp_q[$];

    dmac_core #(.ADDR_W(AW), .CNT_W(CW), .REG_W(RW)) u_dmac_core (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Arbiter: grant follows the request one cycle later unless held back.
    always @(posedge clk) bus_gnt <= bus_req && !arb_hold && rst_n;

    // Memory model: synchronous read and write.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard compare and bus-behaviour tallies.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R4 write addr/data", {mem_addr, mem_wdata}, e);
                end
            end
            if (mem_re) reads_seen++;
            if (bus_req && !prev_req) begin
                if (tenures > 0 && low_run < 1) gap_bad++;
                tenures++;
            end
            low_run = bus_req ? 0 : low_run + 1;
            prev_req = bus_req;
            if (!bus_gnt && (mem_addr != '0 || mem_wdata != '0 || mem_re || mem_we)) quiet_bad++;
            if (cfg_rdata_busy() && irq) irq_bad++;
        end
    end

    function automatic bit cfg_rdata_busy();
        return u_dmac_core.bus_req || (tenures > 0 && exp_q.size() != 0);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [RW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [RW-1:0] v);
        cfg_sel = sel;
        #1;
        v = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [RW-1:0] c;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            rd(2'd3, c);
            if (!c[0]) break;
        end
    endtask

    task automatic reset_stats();
        tenures = 0; gap_bad = 0; quiet_bad = 0; irq_bad = 0; reads_seen = 0;
    endtask

    // Driver: program a block and push the expected writes.
    task automatic run_xfer(input logic [7:0] s, input logic [7:0] d, input int n, input bit steal);
        logic [RW-1:0] v;
        reset_stats();
        wr(2'd0, s);
        wr(2'd1, d);
        wr(2'd2, n[7:0]);
        for (int i = 0; i < n; i++) begin
            logic [7:0] sa;
            logic [7:0] da;
            sa = s + i[7:0];
            da = d + i[7:0];
            exp_q.push_back({da, mem[sa]});
        end
        wr(2'd3, {5'd0, 1'b0, steal, 1'b1});
        wait_idle();
        @(negedge clk);
        chk(exp_q.size() == 0, "R4 all bytes written", exp_q.size(), 0);
        rd(2'd2, v); chk(v == 0, "R4 count ends at zero", v, 0);
        rd(2'd0, v); chk(v == s + n[7:0], "R4 source advanced", v, s + n[7:0]);
        if (steal) begin
            chk(tenures == n, "R6 one tenure per byte", tenures, n);
            chk(gap_bad == 0, "R6 request gap", gap_bad, 0);
        end else begin
            chk(tenures == 1, "R5 single tenure", tenures, 1);
        end
        chk(quiet_bad == 0, "R3 bus quiet without grant", quiet_bad, 0);
        chk(irq == 1'b1, "R7 interrupt at end", irq, 1);
        rd(2'd3, v); chk(v[2] == 1'b1 && v[1] == steal, "R2 control readback", v, {steal, 1'b0} | 3'b100);
    endtask

    initial begin
        logic [RW-1:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!bus_req && !irq && mem_addr == 0 && !mem_re && !mem_we && mem_wdata == 0, "R1 outputs at reset", {bus_req, irq, mem_re, mem_we}, 0);
        rd(2'd0, v); chk(v == 0, "R1 source at reset", v, 0);
        rd(2'd3, v); chk(v == 0, "R1 control at reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk(v == 0, "R1 idle after reset", v, 0);

        // R2: register readback
        wr(2'd0, 8'h3C); wr(2'd1, 8'hA5); wr(2'd2, 8'h07);
        rd(2'd0, v); chk(v == 8'h3C, "R2 source readback", v, 8'h3C);
        rd(2'd1, v); chk(v == 8'hA5, "R2 destination readback", v, 8'hA5);
        rd(2'd2, v); chk(v == 8'h07, "R2 count readback", v, 8'h07);

        // R4 R5: burst block
        run_xfer(8'h10, 8'h80, 5, 1'b0);
        // R7: interrupt stays until cleared
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R7 interrupt held", irq, 1);
        wr(2'd3, 8'h04);
        chk(irq == 1'b0, "R7 interrupt cleared", irq, 0);
        chk(irq_bad == 0, "R7 no interrupt while busy", irq_bad, 0);

        // R6: cycle-steal block
        run_xfer(8'h20, 8'h90, 4, 1'b1);
        wr(2'd3, 8'h04);

        // R10: wrap across the top of the address space
        run_xfer(8'hFE, 8'h40, 4, 1'b0);
        wr(2'd3, 8'h04);

        // R3 R8: grant held back, writes tried while busy
        reset_stats();
        arb_hold = 1'b1;
        wr(2'd0, 8'h50); wr(2'd1, 8'hB0); wr(2'd2, 8'h03);
        for (int i = 0; i < 3; i++) exp_q.push_back({8'hB0 + 8'(i), mem[8'h50 + i]});
        wr(2'd3, 8'h01);
        repeat (5) @(negedge clk);
        chk(bus_req == 1'b1, "R3 request raised", bus_req, 1);
        chk(reads_seen == 0, "R3 no access without grant", reads_seen, 0);
        wr(2'd0, 8'h77); wr(2'd2, 8'h09); wr(2'd3, 8'h02);
        rd(2'd0, v); chk(v == 8'h50, "R8 source write ignored", v, 8'h50);
        rd(2'd2, v); chk(v == 8'h03, "R8 count write ignored", v, 8'h03);
        rd(2'd3, v); chk(v[1] == 1'b0, "R8 mode write ignored", v[1], 0);
        arb_hold = 1'b0;
        wait_idle();
        @(negedge clk);
        chk(exp_q.size() == 0, "R8 block completed unchanged", exp_q.size(), 0);
        chk(quiet_bad == 0, "R3 quiet while waiting", quiet_bad, 0);
        wr(2'd3, 8'h04);

        // R9: zero-length start
        reset_stats();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        chk(irq == 1'b1, "R9 immediate interrupt", irq, 1);
        rd(2'd3, v); chk(v[0] == 1'b0, "R9 not busy", v[0], 0);
        repeat (3) @(negedge clk);
        chk(tenures == 0, "R9 no bus request", tenures, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule